// File: doc/BRIEF.md
# Bus-Snooping Page Reference Tracker

This unit sits beside the memory controller and watches every transaction on the shared memory bus. For each physical page it keeps two flags. The hit flag means the page has been touched by any access. The dirty flag means the page has been written. Processors and I/O devices put their transactions on the same snoop port and are treated alike. The flags are indexed by physical page number, which is the bus address with the fixed page offset stripped off. Nothing is cached in a translation buffer, and nothing has to be flushed.

Page replacement software reaches the flags through a small I/O command port. A read command returns both flags of one page on the following cycle. A masked clear resets the selected flags of one page. A clear-all command walks every page, one page per cycle, and holds a busy output high while it runs. Bus tracking never stops. When a bus update and a clear hit the same page in the same cycle, the update wins, so no access is ever lost.

Top module: `pgtrk_top`

## Requirements
- R1: After reset every page's hit and dirty flags are 0, `busy` is 0 and `io_rvalid` is 0.
- R2: The page number of a bus access is `bus_addr[ADDR_W-1:PAGE_SHIFT]`. The offset bits below PAGE_SHIFT never select a different page.
- R3: A bus access with `bus_write`=0 sets only the page's hit flag. An access with `bus_write`=1 sets both the hit and dirty flags. The update takes effect on the clock edge after the access is sampled.
- R4: A read command (`io_op`=2'b00) accepted at an edge drives `io_rvalid`=1 after that edge, with `io_rdata` = {dirty, hit} of `io_page`. The value includes every bus access sampled at an earlier edge.
- R5: A masked clear (`io_op`=2'b01) clears the flags selected by `io_mask` (bit 0 hit, bit 1 dirty) of `io_page`. Other flags and other pages are left unchanged.
- R6: If the snooped update of a bus access sampled at edge k-1 reaches the same page as a clear applied at edge k, the flags set by the access stay set.
- R7: A clear-all command (`io_op`=2'b10) raises `busy` for exactly 2^(ADDR_W-PAGE_SHIFT) cycles. During that time it clears page j at the (j+1)th edge after acceptance.
- R8: While `busy` is 1, I/O commands are ignored. No read answer is produced and no masked clear or new clear-all takes effect.
- R9: Bus accesses during a clear-all are still recorded. An update that meets the sweep on its page survives it.
- R10: The reserved opcode 2'b11 has no effect on any flag and produces no read answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A transaction is on the bus this cycle |
| bus_write | input | 1 | The transaction is a write |
| bus_addr | input | ADDR_W | Physical byte address of the transaction |
| io_req | input | 1 | I/O command strobe |
| io_op | input | 2 | 00 read, 01 masked clear, 10 clear all, 11 reserved |
| io_page | input | ADDR_W-PAGE_SHIFT | Page addressed by a read or masked clear |
| io_mask | input | 2 | Flags to clear: bit 0 hit, bit 1 dirty |
| io_rvalid | output | 1 | Read answer valid |
| io_rdata | output | 2 | Read answer {dirty, hit} |
| busy | output | 1 | Clear-all sweep in progress |

## Verification
The assertions take the snoop port as a single stream in which each cycle carries at most one transaction, and they accept any address. They also assume the I/O port sees one command per cycle with a legal opcode. Because busy commands are dropped, the assertions place no rule on issuing commands during a sweep. The stimulus drives at most one bus access and one command per cycle, both on the falling edge. It crowds page numbers into a small set so that updates and clears land on the same page often. It also sends commands while `busy` is high on purpose, because dropping them is checked behaviour and not a violation.

// File: rtl/pgtrk_pkg.sv
package pgtrk_pkg;

    typedef enum logic [1:0] {
        OP_READ     = 2'b00,
        OP_CLR_MASK = 2'b01,
        OP_CLR_ALL  = 2'b10,
        OP_RSVD     = 2'b11
    } io_op_e;

    localparam int FLAG_HIT   = 0;
    localparam int FLAG_DIRTY = 1;
    localparam int FLAG_W     = 2;

endpackage

// File: rtl/pgtrk_snoop.sv
module pgtrk_snoop #(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              upd_valid,
    output logic              upd_write,
    output logic [PAGE_W-1:0] upd_page
);

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [PAGE_W-1:0] page;
    } snp_t;

    snp_t snp_d, snp_q;

    // the offset bits never take part in page selection
    logic offset_unused;
    assign offset_unused = ^bus_addr[PAGE_SHIFT-1:0];

    always_comb begin
        snp_d       = snp_q;
        snp_d.valid = bus_valid;
        snp_d.write = bus_valid & bus_write;
        if (bus_valid) begin
            snp_d.page = bus_addr[ADDR_W-1:PAGE_SHIFT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_q <= '0;
        end else begin
            snp_q <= snp_d;
        end
    end

    assign upd_valid = snp_q.valid;
    assign upd_write = snp_q.write;
    assign upd_page  = snp_q.page;

    // R2: the captured page is the upper address field of the sampled access
    a_r2_page_capture: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> (upd_valid && upd_page == $past(bus_addr[ADDR_W-1:PAGE_SHIFT])));

    // R2: no update is produced without a bus access
    a_r2_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !upd_valid);

endmodule

// File: rtl/pgtrk_bits.sv
module pgtrk_bits
    import pgtrk_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int NPAGES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_write,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic              clr_valid,
    input  logic [PAGE_W-1:0] clr_page,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic [PAGE_W-1:0] rd_page,
    output logic [FLAG_W-1:0] rd_flags
);

    typedef struct packed {
        logic [NPAGES-1:0] hit_v;
        logic [NPAGES-1:0] dirty_v;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // clear first, then the snooped update, so the update wins a collision
        if (clr_valid) begin
            fl_d.hit_v[clr_page]   = fl_q.hit_v[clr_page]   & ~clr_mask[FLAG_HIT];
            fl_d.dirty_v[clr_page] = fl_q.dirty_v[clr_page] & ~clr_mask[FLAG_DIRTY];
        end
        if (upd_valid) begin
            fl_d.hit_v[upd_page] = 1'b1;
            if (upd_write) begin
                fl_d.dirty_v[upd_page] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    // read port forwards an update that has not been written yet
    logic [FLAG_W-1:0] fwd;
    always_comb begin
        fwd = '0;
        if (upd_valid && upd_page == rd_page) begin
            fwd[FLAG_HIT]   = 1'b1;
            fwd[FLAG_DIRTY] = upd_write;
        end
        rd_flags = {fl_q.dirty_v[rd_page], fl_q.hit_v[rd_page]} | fwd;
    end

    // R3: any access leaves the hit flag set
    a_r3_access_sets_hit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> fl_q.hit_v[$past(upd_page)]);

    // R3: a write leaves both flags set
    a_r3_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_write) |=> (fl_q.hit_v[$past(upd_page)] && fl_q.dirty_v[$past(upd_page)]));

    // R5: selected flags are gone after a clear with no colliding update
    a_r5_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(upd_valid && upd_page == clr_page))
        |=> (({fl_q.dirty_v[$past(clr_page)], fl_q.hit_v[$past(clr_page)]} & $past(clr_mask)) == 2'b00));

    // R6: a colliding update survives the clear
    a_r6_update_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && upd_valid && upd_page == clr_page) |=> fl_q.hit_v[$past(clr_page)]);

endmodule

// File: rtl/pgtrk_ctrl.sv
module pgtrk_ctrl
    import pgtrk_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int NPAGES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic [1:0]        io_op,
    input  logic [PAGE_W-1:0] io_page,
    input  logic [FLAG_W-1:0] io_mask,
    input  logic [FLAG_W-1:0] rd_flags,
    output logic [PAGE_W-1:0] rd_page,
    output logic              clr_valid,
    output logic [PAGE_W-1:0] clr_page,
    output logic [FLAG_W-1:0] clr_mask,
    output logic              io_rvalid,
    output logic [FLAG_W-1:0] io_rdata,
    output logic              busy
);

    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NPAGES - 1);

    typedef struct packed {
        logic              busy;
        logic [PAGE_W-1:0] sweep;
        logic              rvalid;
        logic [FLAG_W-1:0] rdata;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    io_op_e op;
    logic   accept;

    always_comb begin
        op        = io_op_e'(io_op);
        accept    = io_req && !ctl_q.busy;
        ctl_d     = ctl_q;
        rd_page   = io_page;
        clr_valid = 1'b0;
        clr_page  = io_page;
        clr_mask  = '0;

        ctl_d.rvalid = accept && (op == OP_READ);
        if (accept && op == OP_READ) begin
            ctl_d.rdata = rd_flags;
        end

        if (ctl_q.busy) begin
            clr_valid = 1'b1;
            clr_page  = ctl_q.sweep;
            clr_mask  = '1;
            if (ctl_q.sweep == LAST_PAGE) begin
                ctl_d.busy  = 1'b0;
                ctl_d.sweep = '0;
            end else begin
                ctl_d.sweep = ctl_q.sweep + 1'b1;
            end
        end else if (accept && op == OP_CLR_MASK) begin
            clr_valid = 1'b1;
            clr_mask  = io_mask;
        end else if (accept && op == OP_CLR_ALL) begin
            ctl_d.busy  = 1'b1;
            ctl_d.sweep = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign io_rvalid = ctl_q.rvalid;
    assign io_rdata  = ctl_q.rdata;
    assign busy      = ctl_q.busy;

    // R4: an accepted read is answered on the next cycle
    a_r4_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !busy && io_op == 2'b00) |=> io_rvalid);

    // R8: nothing is answered for a command seen during a sweep
    a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !io_rvalid);

    // R10: the reserved opcode produces no answer and starts nothing
    a_r10_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !busy && io_op == 2'b11) |=> (!io_rvalid && !busy));

    // R7: a sweep ends only after the last page
    a_r7_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(ctl_q.sweep) == LAST_PAGE));

    // R7: a sweep begins at page zero
    a_r7_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ctl_q.sweep == '0));

endmodule

// File: rtl/pgtrk_top.sv
module pgtrk_top
    import pgtrk_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         io_req,
    input  logic [1:0]                   io_op,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] io_page,
    input  logic [1:0]                   io_mask,
    output logic                         io_rvalid,
    output logic [1:0]                   io_rdata,
    output logic                         busy
);

    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int NPAGES = 1 << PAGE_W;

    logic              upd_valid, upd_write;
    logic [PAGE_W-1:0] upd_page;
    logic              clr_valid;
    logic [PAGE_W-1:0] clr_page, rd_page;
    logic [FLAG_W-1:0] clr_mask, rd_flags;

    pgtrk_snoop #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PAGE_W    (PAGE_W)
    ) u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .upd_valid(upd_valid),
        .upd_write(upd_write),
        .upd_page (upd_page)
    );

    pgtrk_bits #(
        .PAGE_W(PAGE_W),
        .NPAGES(NPAGES)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_valid(upd_valid),
        .upd_write(upd_write),
        .upd_page (upd_page),
        .clr_valid(clr_valid),
        .clr_page (clr_page),
        .clr_mask (clr_mask),
        .rd_page  (rd_page),
        .rd_flags (rd_flags)
    );

    pgtrk_ctrl #(
        .PAGE_W(PAGE_W),
        .NPAGES(NPAGES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_req   (io_req),
        .io_op    (io_op),
        .io_page  (io_page),
        .io_mask  (io_mask),
        .rd_flags (rd_flags),
        .rd_page  (rd_page),
        .clr_valid(clr_valid),
        .clr_page (clr_page),
        .clr_mask (clr_mask),
        .io_rvalid(io_rvalid),
        .io_rdata (io_rdata),
        .busy     (busy)
    );

endmodule

// File: tb/test_pgtrk_top.sv
`timescale 1ns/1ps
module test_pgtrk_top;

    localparam int ADDR_W     = 20;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int NPAGES     = 1 << PAGE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              io_req = 1'b0;
    logic [1:0]        io_op = 2'b00;
    logic [PAGE_W-1:0] io_page = '0;
    logic [1:0]        io_mask = 2'b00;
    logic              io_rvalid;
    logic [1:0]        io_rdata;
    logic              busy;

    always #2.5 clk = ~clk;

    pgtrk_top #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) i_pgtrk_top (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .io_req(io_req), .io_op(io_op), .io_page(io_page), .io_mask(io_mask),
        .io_rvalid(io_rvalid), .io_rdata(io_rdata), .busy(busy)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference state built from the requirements
    bit              m_hit   [NPAGES];
    bit              m_dirty [NPAGES];
    bit              pend_v, pend_w;
    int              pend_pg;
    bit              sweeping;
    int              swc;
    bit              exp_rv;
    logic [1:0]      exp_rd = 2'b00;

    function automatic logic [1:0] model_read(int pg);
        logic [1:0] v;
        v = {m_dirty[pg], m_hit[pg]};
        if (pend_v && pend_pg == pg) v = v | {pend_w, 1'b1};
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock cycle: drive at falling edge, predict, check after the rising edge
    task automatic step(bit bv, bit bw, logic [ADDR_W-1:0] ba,
                        bit iq, logic [1:0] op, int pg, logic [1:0] mk, string req);
        bit acc;
        bus_valid = bv; bus_write = bw; bus_addr = ba;
        io_req = iq; io_op = op; io_page = PAGE_W'(pg); io_mask = mk;

        acc    = iq && !sweeping;
        exp_rv = acc && op == 2'b00;
        if (exp_rv) exp_rd = model_read(pg);
        if (sweeping) begin
            m_hit[swc] = 0; m_dirty[swc] = 0;
        end else if (acc && op == 2'b01) begin
            if (mk[0]) m_hit[pg] = 0;
            if (mk[1]) m_dirty[pg] = 0;
        end
        if (pend_v) begin
            m_hit[pend_pg] = 1;
            if (pend_w) m_dirty[pend_pg] = 1;
        end
        if (sweeping) begin
            if (swc == NPAGES-1) sweeping = 0; else swc++;
        end else if (acc && op == 2'b10) begin
            sweeping = 1; swc = 0;
        end
        pend_v = bv; pend_w = bv && bw; pend_pg = int'(ba[ADDR_W-1:PAGE_SHIFT]);

        @(posedge clk);
        @(negedge clk);
        check(io_rvalid == exp_rv, req, "io_rvalid", io_rvalid, exp_rv);
        if (exp_rv) check(io_rdata == exp_rd, req, "io_rdata", io_rdata, exp_rd);
        check(busy == sweeping, req, "busy", busy, sweeping);
    endtask

    task automatic idle(string req);
        step(0, 0, '0, 0, 2'b00, 0, 2'b00, req);
    endtask

    task automatic rd(int pg, string req);
        step(0, 0, '0, 1, 2'b00, pg, 2'b00, req);
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int pg, int off);
        return {PAGE_W'(pg), PAGE_SHIFT'(off)};
    endfunction

    initial begin
        repeat (20000 * 5) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1987));
        for (int i = 0; i < NPAGES; i++) begin m_hit[i] = 0; m_dirty[i] = 0; end
        pend_v = 0; pend_w = 0; pend_pg = 0; sweeping = 0; swc = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(io_rvalid == 1'b0, "R1", "io_rvalid after reset", io_rvalid, 0);
        rd(0, "R1"); rd(NPAGES-1, "R1"); rd(17, "R1");

        // R3: read access sets hit only, write sets both
        step(1, 0, mk_addr(5, 'h123), 0, 2'b00, 0, 2'b00, "R3");
        rd(5, "R3");
        step(1, 1, mk_addr(9, 'h004), 0, 2'b00, 0, 2'b00, "R3");
        idle("R3");
        rd(9, "R3");

        // R2: offset bits do not change the page; top page reachable
        step(1, 1, mk_addr(200, 'hFFF), 0, 2'b00, 0, 2'b00, "R2");
        rd(200, "R2"); rd(201, "R2"); rd(199, "R2");
        step(1, 0, {ADDR_W{1'b1}}, 0, 2'b00, 0, 2'b00, "R2");
        rd(NPAGES-1, "R2");

        // R4: read in the cycle right after the access sees it
        step(1, 1, mk_addr(30, 0), 0, 2'b00, 0, 2'b00, "R4");
        rd(30, "R4");
        // R4: access and read at the same edge: read shows the old value
        step(1, 0, mk_addr(31, 8), 1, 2'b00, 31, 2'b00, "R4");
        rd(31, "R4");

        // R5: masked clears
        step(0, 0, '0, 1, 2'b01, 9, 2'b10, "R5");
        rd(9, "R5"); rd(30, "R5");
        step(0, 0, '0, 1, 2'b01, 9, 2'b01, "R5");
        rd(9, "R5");

        // R6: update meets a clear of its page
        step(1, 1, mk_addr(40, 0), 0, 2'b00, 0, 2'b00, "R6");
        step(0, 0, '0, 1, 2'b01, 40, 2'b11, "R6");
        rd(40, "R6");

        // R10: reserved opcode leaves page 5 alone and gives no answer
        step(0, 0, '0, 1, 2'b11, 5, 2'b11, "R10");
        rd(5, "R10");

        // R7, R8, R9: clear-all with traffic and commands during the sweep
        step(0, 0, '0, 1, 2'b10, 0, 2'b00, "R7");
        step(1, 1, mk_addr(250, 0), 1, 2'b00, 250, 2'b00, "R8");
        step(0, 0, '0, 1, 2'b01, 250, 2'b11, "R8");
        step(1, 0, mk_addr(2, 0), 0, 2'b00, 0, 2'b00, "R9");
        step(1, 1, mk_addr(4, 0), 0, 2'b00, 0, 2'b00, "R9");
        for (int i = 0; i < NPAGES; i++) idle("R7");
        rd(250, "R9"); rd(2, "R9"); rd(4, "R9"); rd(5, "R7"); rd(200, "R7");

        // random mix, pages crowded into a small set to force collisions
        for (int i = 0; i < 3000; i++) begin
            int  pg, pr, r;
            bit  bv, bw, iq;
            logic [1:0] op;
            pg = ($urandom % 4 == 0) ? int'($urandom % NPAGES) : int'($urandom % 6);
            pr = ($urandom % 4 == 0) ? int'($urandom % NPAGES) : int'($urandom % 6);
            bv = ($urandom % 10) < 6;
            bw = $urandom % 2;
            iq = ($urandom % 10) < 4;
            r  = $urandom % 100;
            op = (r < 60) ? 2'b00 : (r < 90) ? 2'b01 : (r < 93) ? 2'b10 : 2'b11;
            step(bv, bw, mk_addr(pg, $urandom % 4096), iq, op, pr, 2'($urandom), "R3/R4/R5/R6");
        end
        while (sweeping) idle("R7");
        for (int p = 0; p < NPAGES; p++) rd(p, "R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule